// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a single column command into the stream of column addresses a synchronous memory burst walks through. On a start command it captures the start column and the current burst configuration. From the next cycle it presents one column per clock with a beat-valid flag, until the burst runs out, is stopped, or is replaced by a new command.

The burst length can be one, two, four or eight beats, or a whole 256-column page. Finite bursts stay inside the aligned window of their own length and use either sequential or interleaved order. A page burst counts upward through the page, wraps from the last column to column 0, and runs until it is stopped. A separate mode makes every write a single beat while reads keep the programmed length. Data movement and the memory array belong to other blocks.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and with no command pending, `beat_valid_o` and `done_o` are low.
- R2: A cycle with `start_i` high is followed, on the next cycle, by beat 0 with `beat_valid_o` high and `col_o` equal to the `start_col_i` value sampled with the command.
- R3: `len_code_i` selects the burst length L: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives a full page, and 4, 5 and 6 give 1. A finite burst gives exactly L back-to-back valid beats. `beat_valid_o` is low on the cycle after the last beat.
- R4: With `interleave_i` low and a finite L, beat k carries column `(S & ~(L-1)) | ((S + k) & (L-1))`, where S is the start column.
- R5: With `interleave_i` high and a finite L, beat k carries column `(S & ~(L-1)) | ((S ^ k) & (L-1))`.
- R6: A full-page burst always uses upward order, whatever `interleave_i` is. Beat k carries `(S + k) mod 256`, wrapping from 255 to 0, and the burst continues until it is stopped.
- R7: `done_o` is high on the last beat of a finite burst and low on its other beats. It is never high during a full-page burst unless `stop_i` is high.
- R8: `stop_i` high on a valid beat makes that beat the last one: `done_o` is high on that cycle and `beat_valid_o` is low on the next, unless a new command starts.
- R9: `start_i` high during a burst cuts it short. The current beat is still shown, with `done_o` low. The next cycle shows beat 0 of the new burst.
- R10: When `single_wr_i` is high and `is_write_i` is high, the burst has length 1 whatever `len_code_i` is. Reads still use the programmed length.
- R11: `start_col_i`, `len_code_i`, `interleave_i`, `single_wr_i` and `is_write_i` are sampled only on a `start_i` cycle. Changing them during a burst does not change its columns or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command; starts a new burst |
| is_write_i | input | 1 | Command is a write |
| start_col_i | input | 8 | Start column of the command |
| stop_i | input | 1 | Ends the burst on the current beat |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 selects interleaved order |
| single_wr_i | input | 1 | Forces writes to a single beat |
| col_o | output | 8 | Column of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| done_o | output | 1 | The current beat is the last one |

## Verification
The bench targets these faults:
- Start columns near the top of a window or the page. A generator that lets a carry leave the window would step into the next aligned block, or past column 255 in page mode.
- Interleaved order checked against sequential order from unaligned starts. Mixing up XOR and add shows up there.
- A stop, and a new command, placed in the middle of a burst. Mishandling either gives a missing or extra `done_o`, or stale beats.
- Configuration inputs changed at random after every command. A design that reads them live rather than latching them would change length or order mid-burst.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [2:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_PAGE = 3'd7
  } bl_code_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code_i,
  input  logic             single_wr_i,
  input  logic             is_write_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  import bcg_pkg::*;

  always_comb begin
    full_o = 1'b0;
    mask_o = '0;
    if (!(single_wr_i && is_write_i)) begin
      case (bl_code_e'(code_i))
        BL_2:    mask_o = COL_W'(1);
        BL_4:    mask_o = COL_W'(3);
        BL_8:    mask_o = COL_W'(7);
        BL_PAGE: begin
          mask_o = '1;
          full_o = 1'b1;
        end
        default: mask_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/bcg_seq_ctrl.sv
module bcg_seq_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_d_i,
  input  logic             full_d_i,
  input  logic             il_d_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             il_o
);
  logic busy_q, full_q, il_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic last_beat;

  assign last_beat = !full_q && (cnt_q == mask_q);
  assign done_o    = busy_q && !start_i && (last_beat || stop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      full_q <= 1'b0;
      il_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      base_q <= start_col_i;
      cnt_q  <= '0;
      mask_q <= mask_d_i;
      full_q <= full_d_i;
      il_q   <= il_d_i && !full_d_i; // page bursts always count upward
    end else if (busy_q) begin
      if (last_beat || stop_i) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign base_o = base_q;
  assign cnt_o  = cnt_q;
  assign mask_o = mask_q;
  assign full_o = full_q;
  assign il_o   = il_q;
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum, mix;
  assign sum = base_i + cnt_i;
  assign mix = base_i ^ cnt_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? (il_i ? mix[i] : sum[i]) : base_i[i];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_write_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             stop_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_valid_o,
  output logic             done_o
);
  logic [COL_W-1:0] mask_d, base_q, cnt_q, mask_q;
  logic full_d, full_q, il_q;

  bcg_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i(len_code_i), .single_wr_i(single_wr_i), .is_write_i(is_write_i),
    .mask_o(mask_d), .full_o(full_d)
  );

  bcg_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .start_col_i(start_col_i), .mask_d_i(mask_d), .full_d_i(full_d),
    .il_d_i(interleave_i), .busy_o(beat_valid_o), .done_o(done_o),
    .base_o(base_q), .cnt_o(cnt_q), .mask_o(mask_q), .full_o(full_q), .il_o(il_q)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base_i(base_q), .cnt_i(cnt_q), .mask_i(mask_q), .il_i(il_q), .col_o(col_o)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic             is_write_i,
  input logic             single_wr_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_valid_o,
  input logic             done_o,
  input logic [COL_W-1:0] mask_i,
  input logic             full_i
);
  assert_start_beat0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (beat_valid_o && col_o == $past(start_col_i)));

  assert_done_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !beat_valid_o);

  assert_window_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !done_o && !start_i) |=>
      ((col_o & ~mask_i) == ($past(col_o) & ~$past(mask_i))));

  assert_page_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && full_i && !stop_i && !start_i) |=>
      (beat_valid_o && col_o == COL_W'($past(col_o) + 1'b1)));

  assert_page_no_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && full_i && !stop_i) |-> !done_o);

  assert_done_needs_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> beat_valid_o);

  assert_stop_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && stop_i && !start_i) |-> done_o);

  assert_single_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && single_wr_i && is_write_i) |=> done_o || start_i || stop_i || 1'b0 ? done_o || start_i : done_o);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .is_write_i(is_write_i), .single_wr_i(single_wr_i), .start_col_i(start_col_i),
  .col_o(col_o), .beat_valid_o(beat_valid_o), .done_o(done_o),
  .mask_i(mask_q), .full_i(full_q)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, is_write = 1'b0, stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       interleave = 1'b0, single_wr = 1'b0;
  logic [7:0] col;
  logic       valid, done;
  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .is_write_i(is_write),
    .start_col_i(start_col), .stop_i(stop), .len_code_i(len_code),
    .interleave_i(interleave), .single_wr_i(single_wr),
    .col_o(col), .beat_valid_o(valid), .done_o(done)
  );

  function automatic int exp_len(input logic [2:0] code, input logic br, input logic wr);
    if (br && wr) return 1;
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0; // full page
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int k,
                                         input int len, input logic il);
    logic [7:0] m, kk;
    kk = 8'(k);
    if (len == 0) return 8'(s + kk);
    m = 8'(len - 1);
    if (il) return (s & ~m) | ((s ^ kk) & m);
    return (s & ~m) | (8'(s + kk) & m);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic scramble();
    start_col  = 8'($urandom);
    len_code   = 3'($urandom);
    interleave = 1'($urandom);
    single_wr  = 1'($urandom);
    is_write   = 1'($urandom);
  endtask

  // At a negedge: drive the command for one cycle, then scramble the config (R11)
  task automatic issue(input logic [7:0] s, input logic wr, input logic [2:0] code,
                       input logic il, input logic br);
    @(negedge clk);
    start = 1'b1; start_col = s; is_write = wr; len_code = code;
    interleave = il; single_wr = br;
    @(negedge clk);
    start = 1'b0;
    scramble();
  endtask

  task automatic expect_beats(input logic [7:0] s, input int len, input logic il,
                              input int stop_at, input int count, input string req);
    for (int k = 0; k < count; k++) begin
      stop = (k == stop_at);
      #1;
      check(req, "valid", int'(valid), 1);
      check(req, "col", int'(col), int'(exp_col(s, k, len, il && len != 0)));
      check("R7", "done", int'(done), int'((len != 0 && k == len - 1) || k == stop_at));
      @(negedge clk);
    end
    stop = 1'b0;
  endtask

  task automatic expect_idle(input string req);
    #1;
    check(req, "valid after end", int'(valid), 0);
    check(req, "done after end", int'(done), 0);
  endtask

  task automatic burst(input logic [7:0] s, input logic wr, input logic [2:0] code,
                       input logic il, input logic br, input int stop_at, input string req);
    int len, n;
    len = exp_len(code, br, wr);
    issue(s, wr, code, il, br);
    if (len == 0) n = stop_at + 1;
    else if (stop_at >= 0 && stop_at < len) n = stop_at + 1;
    else n = len;
    expect_beats(s, len, il, stop_at, n, req);
    expect_idle(req);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    check("R1", "valid in reset", int'(valid), 0);
    check("R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1", "valid idle", int'(valid), 0);
    @(negedge clk);

    // Directed corners
    burst(8'd7,   1'b0, 3'd0, 1'b0, 1'b0, -1, "R3");  // length 1
    burst(8'd13,  1'b0, 3'd2, 1'b0, 1'b0, -1, "R4");  // seq wrap in window of 4
    burst(8'd255, 1'b0, 3'd3, 1'b0, 1'b0, -1, "R4");  // seq at page top stays in window
    burst(8'd13,  1'b0, 3'd2, 1'b1, 1'b0, -1, "R5");  // interleave 4
    burst(8'd94,  1'b1, 3'd3, 1'b1, 1'b0, -1, "R5");  // interleave 8
    burst(8'd5,   1'b0, 3'd5, 1'b0, 1'b0, -1, "R3");  // reserved code -> 1
    burst(8'd250, 1'b0, 3'd7, 1'b1, 1'b0, 299, "R6"); // page wrap, interleave ignored
    burst(8'd40,  1'b0, 3'd3, 1'b0, 1'b0, 2, "R8");   // stop mid burst
    burst(8'd3,   1'b1, 3'd3, 1'b0, 1'b1, -1, "R10"); // single write forced
    burst(8'd3,   1'b0, 3'd3, 1'b0, 1'b1, -1, "R10"); // read keeps length
    burst(8'd33,  1'b0, 3'd1, 1'b0, 1'b0, -1, "R11");

    // Interrupt: new command on beat 3 of an 8-beat burst
    issue(8'd16, 1'b0, 3'd3, 1'b0, 1'b0);
    expect_beats(8'd16, 8, 1'b0, -1, 3, "R9");
    start = 1'b1; start_col = 8'd201; is_write = 1'b0; len_code = 3'd2;
    interleave = 1'b1; single_wr = 1'b0;
    #1;
    check("R9", "old beat col", int'(col), 19);
    check("R9", "old beat done", int'(done), 0);
    @(negedge clk);
    start = 1'b0;
    scramble();
    expect_beats(8'd201, 4, 1'b1, -1, 4, "R9");
    expect_idle("R9");

    // Random bursts
    for (int i = 0; i < 60; i++) begin
      logic [7:0] s;
      logic [2:0] c;
      logic w, il, br;
      int sa;
      s = 8'($urandom); c = 3'($urandom); w = 1'($urandom);
      il = 1'($urandom); br = 1'($urandom);
      sa = ($urandom % 4 == 0) ? int'($urandom % 8) : -1;
      if (exp_len(c, br, w) == 0) sa = 5 + int'($urandom % 300);
      burst(s, w, c, il, br, sa, "R4");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule